// File: doc/BRIEF.md
# Shared-Buffer Command Engine

This block is the device side of a memory-mapped control window. A host moves commands and responses through one shared buffer instead of a streaming data port. Before it may touch the buffer, the host claims the block through a locality grant. It then asks the engine to leave its low-power idle state and become ready. Once ready, it writes a command into the buffer and sets a start flag. The engine clears the start flag when the work is done, or when the host cancels the work part-way. Read-only registers tell the host where the buffer lives and how large it is. Commands and responses share one region, so both address registers report the same value and both size registers report the same value.

The engine does not execute real commands. A stub waits for the number of cycles given on the `stub_latency` input and then writes a 10-byte response header at the start of the buffer. The header holds a fixed two-byte tag, a big-endian total length of 10 in bytes 2 to 5, and a big-endian return code in bytes 6 to 9. A return code of zero means success. A cancelled command gets a non-zero code instead.

The register bus is a single-cycle, 32-bit word interface. A write takes effect at the clock edge where `bus_valid` and `bus_write` are both high. Reads are combinational from `bus_addr`. Buffer byte n sits in word n/4, at bits 8*(n%4)+7 down to 8*(n%4).

Top module: `crb_engine`

## Requirements
- R1: After reset, the register reads are: locality state 0x0000_0080 (valid only), control status 0x0000_0002 (idle, no error), control request 0, start 0 and cancel 0.
- R2: Writing bit0 of the locality control register (0x08) sets assigned (bit1) and established (bit0) of the locality state (0x00) from the next cycle, so it reads 0x83. Writing bit1 clears assigned from the next cycle, so it reads 0x81, and established stays set.
- R3: Writing bit0 of the control request register (0x40) holds that bit at 1 for exactly PWR_LAT cycles. The bit then reads 0, and the idle bit (bit1) of control status (0x44) reads 0. Go-idle and go-ready are never pending together.
- R4: Writing bit1 of 0x40 holds that bit at 1 for exactly PWR_LAT cycles. The bit then reads 0, and the idle bit of 0x44 reads 1.
- R5: A write of 1 to the start register (0x4C) is accepted only when the locality is assigned, the engine is ready and not executing, and no error is flagged. A refused start leaves 0x4C reading 0.
- R6: An accepted start reads 1 for exactly `stub_latency` cycles and then 0. At that point buffer words 0, 1 and 2 read 0x0000_0180, 0x0000_0A00 and 0x0000_0000 in bits 15:0, which encodes length 10 and return code 0.
- R7: If the cancel register (0x48) holds 1 during execution, start clears one cycle later. The header then carries return code 0x0000_0101, so bits 15:0 of word 2 read 0x0101, and word 1 still reads 0x0000_0A00.
- R8: Buffer writes at 0x80 and above take effect only while the locality is assigned, the engine is ready and no command is executing. Any other buffer write leaves the word unchanged.
- R9: Command size (0x58) and response size (0x64) both read BUF_BYTES. The low address registers (0x5C, 0x68) both read the low half of BASE_ADDR+0x80, and the high address registers (0x60, 0x6C) both read its upper half.
- R10: A one-cycle pulse on `exec_fault` sets the error bit (bit0 of 0x44) from the next cycle. The bit stays set until reset, and a start written while it is set is refused.
- R11: The interrupt enable register (0x50) stores only its global enable in bit31. Writing 0xFFFF_FFFF reads back 0x8000_0000.
- R12: Bit0 of the cancel register reads back the last value written to it.
- R13: Go-ready and go-idle writes made while a command executes are ignored. Control request stays 0 and the engine stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the 32-bit word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| exec_fault | input | 1 | Fatal error pulse from the execution side |
| stub_latency | input | LAT_W | Cycles the stub takes to finish a command |

## Verification
Most internal faults show up within one cycle as a wrong bit in a readable register. A lost locality grant reads as assigned=0. A stuck power transition leaves a request bit high past PWR_LAT cycles. A wrong busy flag appears at once in the start register. A counter that runs off by one moves the cycle where start or a request bit falls, so the bench counts those cycles exactly rather than waiting for the level. A wrong header byte order or return code only becomes visible after completion, in buffer words 1 and 2.

// File: rtl/crb_pkg.sv
package crb_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef enum logic {
        PWR_IDLE  = 1'b0,
        PWR_READY = 1'b1
    } pwr_state_e;

    // Register offsets; the host software decodes these, so they are fixed.
    localparam logic [ADDR_W-1:0] OFS_LOC_STATE = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_LOC_CTRL  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CTRL_REQ  = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_CTRL_STS  = 12'h044;
    localparam logic [ADDR_W-1:0] OFS_CANCEL    = 12'h048;
    localparam logic [ADDR_W-1:0] OFS_START     = 12'h04C;
    localparam logic [ADDR_W-1:0] OFS_INT_EN    = 12'h050;
    localparam logic [ADDR_W-1:0] OFS_CMD_SIZE  = 12'h058;
    localparam logic [ADDR_W-1:0] OFS_CMD_LO    = 12'h05C;
    localparam logic [ADDR_W-1:0] OFS_CMD_HI    = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_RSP_SIZE  = 12'h064;
    localparam logic [ADDR_W-1:0] OFS_RSP_LO    = 12'h068;
    localparam logic [ADDR_W-1:0] OFS_RSP_HI    = 12'h06C;
    localparam logic [ADDR_W-1:0] OFS_BUF       = 12'h080;

    localparam logic [DATA_W-1:0] HDR_LEN = 32'd10;
    localparam logic [15:0]       HDR_TAG = 16'h8001;

endpackage

// File: rtl/crb_locality.sv
module crb_locality (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_req,
    input  logic release_req,
    output logic assigned,
    output logic established
);

    typedef struct packed {
        logic assigned;
        logic established;
    } loc_t;

    loc_t loc_d, loc_q;

    // R2: release wins over a simultaneous request
    always_comb begin
        loc_d = loc_q;
        if (release_req) begin
            loc_d.assigned = 1'b0;
        end else if (grant_req) begin
            loc_d.assigned    = 1'b1;
            loc_d.established = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) loc_q <= '0;
        else        loc_q <= loc_d;
    end

    assign assigned    = loc_q.assigned;
    assign established = loc_q.established;

endmodule

// File: rtl/crb_power.sv
module crb_power
    import crb_pkg::*;
#(
    parameter int PWR_LAT = 4,
    localparam int CNT_W  = $clog2(PWR_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_ready,
    input  logic go_idle,
    output logic ready,
    output logic pend_ready,
    output logic pend_idle
);

    typedef struct packed {
        pwr_state_e       state;
        logic             pend_ready;
        logic             pend_idle;
        logic [CNT_W-1:0] cnt;
    } pwr_t;

    pwr_t pwr_d, pwr_q;

    // R3, R4: a request stays pending PWR_LAT cycles, then commits
    always_comb begin
        pwr_d = pwr_q;
        if (pwr_q.pend_ready || pwr_q.pend_idle) begin
            if (pwr_q.cnt <= CNT_W'(1)) begin
                pwr_d.state      = pwr_q.pend_idle ? PWR_IDLE : PWR_READY;
                pwr_d.pend_ready = 1'b0;
                pwr_d.pend_idle  = 1'b0;
                pwr_d.cnt        = '0;
            end else begin
                pwr_d.cnt = pwr_q.cnt - CNT_W'(1);
            end
        end else if (go_idle) begin
            pwr_d.pend_idle = 1'b1;
            pwr_d.cnt       = CNT_W'(PWR_LAT);
        end else if (go_ready) begin
            pwr_d.pend_ready = 1'b1;
            pwr_d.cnt        = CNT_W'(PWR_LAT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q.state      <= PWR_IDLE;
            pwr_q.pend_ready <= 1'b0;
            pwr_q.pend_idle  <= 1'b0;
            pwr_q.cnt        <= '0;
        end else begin
            pwr_q <= pwr_d;
        end
    end

    assign ready      = (pwr_q.state == PWR_READY);
    assign pend_ready = pwr_q.pend_ready;
    assign pend_idle  = pwr_q.pend_idle;

endmodule

// File: rtl/crb_exec.sv
module crb_exec #(
    parameter int          LAT_W     = 8,
    parameter logic [31:0] CANCEL_RC = 32'h0000_0101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             cancel,
    input  logic [LAT_W-1:0] latency,
    output logic             busy,
    output logic             hdr_we,
    output logic [31:0]      hdr_rc
);

    typedef struct packed {
        logic             busy;
        logic [LAT_W-1:0] cnt;
    } exec_t;

    exec_t exec_d, exec_q;

    // R6: finish after `latency` cycles; R7: cancel aborts one cycle later
    always_comb begin
        exec_d = exec_q;
        hdr_we = 1'b0;
        hdr_rc = '0;
        if (exec_q.busy) begin
            if (cancel) begin
                exec_d.busy = 1'b0;
                hdr_we      = 1'b1;
                hdr_rc      = CANCEL_RC;
            end else if (exec_q.cnt <= LAT_W'(1)) begin
                exec_d.busy = 1'b0;
                hdr_we      = 1'b1;
            end else begin
                exec_d.cnt = exec_q.cnt - LAT_W'(1);
            end
        end else if (start_req) begin
            exec_d.busy = 1'b1;
            exec_d.cnt  = latency;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) exec_q <= '0;
        else        exec_q <= exec_d;
    end

    assign busy = exec_q.busy;

endmodule

// File: rtl/crb_buffer.sv
module crb_buffer
    import crb_pkg::*;
#(
    parameter int  WORDS = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [31:0]      host_wdata,
    input  logic             hdr_we,
    input  logic [31:0]      hdr_rc,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);

    logic [31:0] mem_d [WORDS];
    logic [31:0] mem_q [WORDS];

    // Header bytes land big-endian in a little-endian word layout (R6, R7)
    always_comb begin
        mem_d = mem_q;
        if (host_we) mem_d[host_idx] = host_wdata;
        if (hdr_we) begin
            mem_d[0] = {HDR_LEN[23:16], HDR_LEN[31:24], HDR_TAG[7:0], HDR_TAG[15:8]};
            mem_d[1] = {hdr_rc[23:16], hdr_rc[31:24], HDR_LEN[7:0], HDR_LEN[15:8]};
            mem_d[2] = {mem_q[2][31:16], hdr_rc[7:0], hdr_rc[15:8]};
        end
    end

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[gi] <= '0;
            else        mem_q[gi] <= mem_d[gi];
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/crb_engine.sv
module crb_engine
    import crb_pkg::*;
#(
    parameter int          BUF_BYTES = 64,
    parameter int          PWR_LAT   = 4,
    parameter int          LAT_W     = 8,
    parameter logic [63:0] BASE_ADDR = 64'h0000_0001_FED4_0000,
    parameter logic [31:0] CANCEL_RC = 32'h0000_0101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             exec_fault,
    input  logic [LAT_W-1:0] stub_latency
);

    localparam int          BUF_WORDS = BUF_BYTES / 4;
    localparam int          IDX_W     = $clog2(BUF_WORDS);
    localparam logic [63:0] BUF_ADDR  = BASE_ADDR + 64'(OFS_BUF);
    localparam logic [ADDR_W-1:0] BUF_END = OFS_BUF + ADDR_W'(BUF_BYTES);

    typedef struct packed {
        logic cancel;
        logic int_en;
        logic fault;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              loc_assigned, loc_established;
    logic              pwr_ready, pwr_pend_ready, pwr_pend_idle;
    logic              exec_busy, hdr_we;
    logic [31:0]       hdr_rc, buf_rdata;
    logic              wr_en, in_buf, host_buf_we, start_req;
    logic              go_ready, go_idle, grant_req, release_req;
    logic [ADDR_W-1:0] buf_off;
    logic [IDX_W-1:0]  buf_idx;
    logic              fault_flag, cancel_flag;
    logic              unused_bits;

    // ---------------- decode ----------------
    always_comb begin
        wr_en   = bus_valid && bus_write;
        in_buf  = (bus_addr >= OFS_BUF) && (bus_addr < BUF_END);
        buf_off = bus_addr - OFS_BUF;
        buf_idx = buf_off[IDX_W+1:2];

        grant_req   = wr_en && (bus_addr == OFS_LOC_CTRL) && bus_wdata[0];
        release_req = wr_en && (bus_addr == OFS_LOC_CTRL) && bus_wdata[1];
        // R13: power requests ignored while a command runs
        go_ready = wr_en && (bus_addr == OFS_CTRL_REQ) && bus_wdata[0] && !exec_busy;
        go_idle  = wr_en && (bus_addr == OFS_CTRL_REQ) && bus_wdata[1] && !exec_busy;
        // R5, R10: start guarded by grant, ready, not busy, no error
        start_req = wr_en && (bus_addr == OFS_START) && bus_wdata[0]
                    && loc_assigned && pwr_ready && !exec_busy && !ctl_q.fault
                    && !pwr_pend_ready && !pwr_pend_idle;
        // R8: buffer writes only in the ready, granted, not-busy window
        host_buf_we = wr_en && in_buf && loc_assigned && pwr_ready && !exec_busy;
    end

    // ---------------- control registers ----------------
    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && (bus_addr == OFS_CANCEL)) ctl_d.cancel = bus_wdata[0];  // R12
        if (wr_en && (bus_addr == OFS_INT_EN)) ctl_d.int_en = bus_wdata[31]; // R11
        if (exec_fault)                        ctl_d.fault  = 1'b1;          // R10
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign fault_flag  = ctl_q.fault;
    assign cancel_flag = ctl_q.cancel;

    // ---------------- sub-blocks ----------------
    crb_locality i_locality (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_req   (grant_req),
        .release_req (release_req),
        .assigned    (loc_assigned),
        .established (loc_established)
    );

    crb_power #(.PWR_LAT(PWR_LAT)) i_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_ready   (go_ready),
        .go_idle    (go_idle),
        .ready      (pwr_ready),
        .pend_ready (pwr_pend_ready),
        .pend_idle  (pwr_pend_idle)
    );

    crb_exec #(.LAT_W(LAT_W), .CANCEL_RC(CANCEL_RC)) i_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .cancel    (ctl_q.cancel),
        .latency   (stub_latency),
        .busy      (exec_busy),
        .hdr_we    (hdr_we),
        .hdr_rc    (hdr_rc)
    );

    crb_buffer #(.WORDS(BUF_WORDS)) i_buffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_buf_we),
        .host_idx   (buf_idx),
        .host_wdata (bus_wdata),
        .hdr_we     (hdr_we),
        .hdr_rc     (hdr_rc),
        .rd_idx     (buf_idx),
        .rd_data    (buf_rdata)
    );

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (in_buf) begin
            bus_rdata = buf_rdata;
        end else begin
            unique case (bus_addr)
                OFS_LOC_STATE: bus_rdata = {24'd0, 1'b1, 5'd0, loc_assigned, loc_established};
                OFS_CTRL_REQ:  bus_rdata = {30'd0, pwr_pend_idle, pwr_pend_ready};
                OFS_CTRL_STS:  bus_rdata = {30'd0, !pwr_ready, ctl_q.fault};
                OFS_CANCEL:    bus_rdata = {31'd0, ctl_q.cancel};
                OFS_START:     bus_rdata = {31'd0, exec_busy};
                OFS_INT_EN:    bus_rdata = {ctl_q.int_en, 31'd0};
                OFS_CMD_SIZE,
                OFS_RSP_SIZE:  bus_rdata = 32'(BUF_BYTES);   // R9
                OFS_CMD_LO,
                OFS_RSP_LO:    bus_rdata = BUF_ADDR[31:0];
                OFS_CMD_HI,
                OFS_RSP_HI:    bus_rdata = BUF_ADDR[63:32];
                default:       bus_rdata = '0;
            endcase
        end
    end

    assign unused_bits = ^{buf_off[1:0], buf_off[ADDR_W-1:IDX_W+2], bus_wdata[30:2]};

endmodule

// File: rtl/crb_engine_checker.sv
module crb_engine_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        exec_fault,
    input logic        assigned,
    input logic        ready,
    input logic        pend_ready,
    input logic        pend_idle,
    input logic        busy,
    input logic        cancel,
    input logic        fault
);

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 12'h008 && bus_wdata[1]) |=> !assigned); // R2

    AST_PEND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_ready, pend_idle})); // R3

    AST_START_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(assigned && ready && !fault)); // R5

    AST_CANCEL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cancel) |=> !busy); // R7

    AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_fault |=> fault); // R10

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault); // R10

    AST_READY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ready && !pend_ready && !pend_idle)); // R13

endmodule

bind crb_engine crb_engine_checker i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .exec_fault (exec_fault),
    .assigned   (loc_assigned),
    .ready      (pwr_ready),
    .pend_ready (pwr_pend_ready),
    .pend_idle  (pwr_pend_idle),
    .busy       (exec_busy),
    .cancel     (cancel_flag),
    .fault      (fault_flag)
);

// File: tb/test_crb_engine.sv
`timescale 1ns/1ps
module test_crb_engine;

    localparam int LAT = 6;
    localparam int PWR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        exec_fault = 1'b0;
    logic [7:0]  stub_latency = 8'(LAT);

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    crb_engine #(.PWR_LAT(PWR)) i_crb_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .exec_fault   (exec_fault),
        .stub_latency (stub_latency)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h000, 32'h0, 32'h0000_0080, 4'd1},  // R1 locality state
        '{1'b0, 12'h044, 32'h0, 32'h0000_0002, 4'd1},  // R1 status idle
        '{1'b0, 12'h040, 32'h0, 32'h0000_0000, 4'd1},  // R1 request
        '{1'b0, 12'h04C, 32'h0, 32'h0000_0000, 4'd1},  // R1 start
        '{1'b0, 12'h048, 32'h0, 32'h0000_0000, 4'd1},  // R1 cancel
        '{1'b0, 12'h058, 32'h0, 32'h0000_0040, 4'd9},  // R9 cmd size
        '{1'b0, 12'h064, 32'h0, 32'h0000_0040, 4'd9},  // R9 rsp size
        '{1'b0, 12'h05C, 32'h0, 32'hFED4_0080, 4'd9},  // R9 cmd lo
        '{1'b0, 12'h068, 32'h0, 32'hFED4_0080, 4'd9},  // R9 rsp lo
        '{1'b0, 12'h060, 32'h0, 32'h0000_0001, 4'd9},  // R9 cmd hi
        '{1'b0, 12'h06C, 32'h0, 32'h0000_0001, 4'd9},  // R9 rsp hi
        '{1'b1, 12'h050, 32'hFFFF_FFFF, 32'h0, 4'd0},
        '{1'b0, 12'h050, 32'h0, 32'h8000_0000, 4'd11}, // R11
        '{1'b1, 12'h048, 32'h1, 32'h0, 4'd0},
        '{1'b0, 12'h048, 32'h0, 32'h0000_0001, 4'd12}, // R12
        '{1'b1, 12'h048, 32'h0, 32'h0, 4'd0},
        '{1'b0, 12'h048, 32'h0, 32'h0000_0000, 4'd12}  // R12
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    // counts cycles during which (reg & mask) stays non-zero, from the current negedge
    task automatic count_high(input logic [11:0] a, input logic [31:0] mask, output int n);
        logic [31:0] v;
        n = 0;
        peek(a, v);
        while (((v & mask) != 0) && n < 1000) begin
            n++;
            @(negedge clk);
            peek(a, v);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL R0 watchdog expired: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
            else begin
                rd(VEC[i].addr, v);
                check(int'(VEC[i].req), v, VEC[i].exp, "table read");
            end
        end

        // R5: start without grant and while idle is refused
        wr(12'h04C, 32'h1); peek(12'h04C, v);
        check(5, v, 32'h0, "start refused before grant");
        // R8: buffer write while not ready is dropped
        wr(12'h080, 32'hDEAD_BEEF); rd(12'h080, v);
        check(8, v, 32'h0, "buffer write while idle");
        // R2: grant
        wr(12'h008, 32'h1); peek(12'h000, v);
        check(2, v, 32'h0000_0083, "locality granted");
        // R3: go-ready pending exactly PWR cycles
        wr(12'h040, 32'h1); count_high(12'h040, 32'h1, n);
        check(3, 32'(n), 32'(PWR), "go-ready pending cycles");
        peek(12'h044, v);
        check(3, v, 32'h0, "status after go-ready");
        // R8: buffer write accepted when ready and granted
        wr(12'h084, 32'h1234_5678); peek(12'h084, v);
        check(8, v, 32'h1234_5678, "buffer write accepted");
        // R6: execution length and header
        wr(12'h04C, 32'h1); count_high(12'h04C, 32'h1, n);
        check(6, 32'(n), 32'(LAT), "start busy cycles");
        peek(12'h080, v); check(6, v, 32'h0000_0180, "header word0");
        peek(12'h084, v); check(6, v, 32'h0000_0A00, "header word1");
        peek(12'h088, v); check(6, v, 32'h0000_0000, "header word2 rc ok");

        // R13 and R8: go-idle and buffer write during execution are ignored
        wr(12'h04C, 32'h1);
        wr(12'h040, 32'h2); peek(12'h040, v);
        check(13, v, 32'h0, "go-idle while busy not pending");
        wr(12'h08C, 32'h0000_AAAA);
        count_high(12'h04C, 32'h1, n);
        peek(12'h044, v); check(13, v, 32'h0, "still ready after busy go-idle");
        peek(12'h08C, v); check(8, v, 32'h0, "buffer write during busy dropped");

        // R7: cancel aborts one cycle after it is set
        wr(12'h04C, 32'h1);
        wr(12'h048, 32'h1); peek(12'h04C, v);
        check(7, v, 32'h1, "start still set in cancel cycle");
        @(negedge clk); peek(12'h04C, v);
        check(7, v, 32'h0, "start cleared by cancel");
        peek(12'h088, v); check(7, v, 32'h0000_0101, "cancel return code");
        peek(12'h084, v); check(7, v, 32'h0000_0A00, "cancel header length");
        wr(12'h048, 32'h0);

        // R2: release, established stays; R5: start refused without grant
        wr(12'h008, 32'h2); peek(12'h000, v);
        check(2, v, 32'h0000_0081, "locality released");
        wr(12'h04C, 32'h1); peek(12'h04C, v);
        check(5, v, 32'h0, "start refused after release");

        // R4: go-idle
        wr(12'h008, 32'h1);
        wr(12'h040, 32'h2); count_high(12'h040, 32'h2, n);
        check(4, 32'(n), 32'(PWR), "go-idle pending cycles");
        peek(12'h044, v); check(4, v, 32'h2, "idle after go-idle");
        wr(12'h04C, 32'h1); peek(12'h04C, v);
        check(5, v, 32'h0, "start refused while idle");

        // R10: fault sticky and blocks start
        wr(12'h040, 32'h1);
        repeat (PWR + 1) @(negedge clk);
        exec_fault = 1'b1;
        @(negedge clk);
        exec_fault = 1'b0;
        peek(12'h044, v); check(10, v, 32'h1, "fault flagged");
        wr(12'h04C, 32'h1); peek(12'h04C, v);
        check(10, v, 32'h0, "start refused in error");
        repeat (5) @(negedge clk);
        peek(12'h044, v); check(10, v, 32'h1, "fault sticky");

        // R1: reset returns to the initial state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(12'h000, v); check(1, v, 32'h0000_0080, "locality after reset");
        peek(12'h044, v); check(1, v, 32'h0000_0002, "status after reset");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule